// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Level Masking

This block gathers interrupt requests from a parameterised set of peripheral sources and decides which one the processor should take. A source takes part only while its peripheral has raised its pending flag and software has enabled it. Each source carries a 3-bit priority level, where a smaller number is more urgent. Every cycle a combinational tournament picks the most urgent live request. When levels are equal, the lower source number wins. The current winner is visible on the pending outputs at all times.

The winner is taken only at an instruction boundary, marked by a one-cycle strobe. It is also taken only if the global interrupt enable is set and the winner's level is strictly below the running level mask. A take produces a registered one-cycle pulse carrying the source number, its level and its per-source routing bit. A routing bit of 0 means the normal software handler and 1 means the hardware data-transfer service. A normal take loads the mask with the taken level, so only more urgent requests can then pre-empt it. A transfer-service take leaves the mask alone. Software can also load the mask directly, for example when it returns from a handler.

Clearing a source's flag or enable removes it from arbitration in the same cycle. Level 7 can never be taken, because no 3-bit mask exceeds it.

Top module: `irq_prio_arbiter`

## Requirements
- R1: `pend_valid` is 1 exactly when at least one source has both `irq_flag` and `irq_en` set. A source with either bit clear never appears on `pend_id`, and clearing either bit drops it in the same cycle.
- R2: Among live sources, `pend_id`, `pend_level` and `pend_xfer` belong to the one with the smallest level. Source i's level is `irq_level[3*i+2:3*i]`.
- R3: When several live sources share the smallest level, the one with the lowest index wins.
- R4: A take requires `int_enable`=1 and `pend_level` strictly less than `level_mask` in the same cycle. A level equal to or above the mask is never taken.
- R5: A take happens only in a cycle where `insn_boundary`=1. It shows as `take_valid` high for one cycle after that clock edge, with `take_id` and `take_level` equal to the winner of that cycle.
- R6: `take_xfer` equals the `irq_xfer_sel` bit of the taken source: 0 means the normal handler, 1 means the transfer service.
- R7: A take with `take_xfer`=0 loads `level_mask` with the taken level on the same edge that raises `take_valid`. A take with `take_xfer`=1 leaves the mask unchanged by the take.
- R8: `mask_load`=1 loads `level_mask` from `mask_load_val` at the next edge, unless a normal take updates the mask on that edge; the take has precedence.
- R9: After synchronous reset, `take_valid` is 0 and `level_mask` is 7.
- R10: A source at level 7 is never taken, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_flag | input | N_SRC | Per-source pending flag from the peripheral |
| irq_en | input | N_SRC | Per-source enable |
| irq_level | input | 3*N_SRC | Per-source 3-bit level, source i at bits 3i+2..3i |
| irq_xfer_sel | input | N_SRC | Per-source route: 0 handler, 1 transfer service |
| int_enable | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | Strobe marking the end of the current instruction |
| mask_load | input | 1 | Direct load of the level mask |
| mask_load_val | input | 3 | Value for the direct mask load |
| pend_valid | output | 1 | A live request exists |
| pend_id | output | clog2(N_SRC) | Current winning source |
| pend_level | output | 3 | Level of the current winner |
| pend_xfer | output | 1 | Route bit of the current winner |
| take_valid | output | 1 | One-cycle take pulse |
| take_id | output | clog2(N_SRC) | Taken source |
| take_level | output | 3 | Level of the taken source |
| take_xfer | output | 1 | Route of the taken source |
| level_mask | output | 3 | Running level mask |

## Verification
The assertions assume that a source's level and route bits are stable while its live request is being evaluated within a cycle. They also assume that inputs change only between clock edges, so the winner seen at an edge is the same one the pending outputs showed just before it. The bench drives every input on the falling edge and holds it through the next rising edge. Levels, enables, flags and routes are drawn freely, including level 7 and ties. The boundary strobe, global enable and direct mask loads are drawn with biased probabilities, so takes, refusals and mask overrides all occur many times.

// File: rtl/irq_arb_pkg.sv
// Shared constants and types for the priority interrupt arbiter.
// Assumes a 3-bit level encoding where 0 is the most urgent value.
package irq_arb_pkg;
    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_NEVER = '1;   // level that can never be taken
    localparam logic [LVL_W-1:0] MASK_RESET = '1;  // mask value after reset
    typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/irq_req_gate.sv
// Gates each source's pending flag with its enable and splits the packed
// level bus into one level per source.
// Assumes: levels are packed 3 bits per source, source 0 in the low bits.
module irq_req_gate
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic [N_SRC-1:0]       flag,
    input  logic [N_SRC-1:0]       en,
    input  logic [LVL_W*N_SRC-1:0] level_bus,
    output logic [N_SRC-1:0]       live,
    output level_t                 level [N_SRC]
);
    // A source is live only while both flag and enable are set.
    assign live = flag & en;

    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_split
            // Extract the level field of source gi.
            assign level[gi] = level_bus[LVL_W*gi +: LVL_W];
        end
    endgenerate
endmodule

// File: rtl/irq_prio_tree.sv
// Combinational tournament that selects the live source with the smallest
// level, breaking ties toward the lower index. Depth grows as log2(N_SRC).
// Assumes N_SRC >= 2. Unused leaves are padded invalid.
module irq_prio_tree
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDW = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] live,
    input  level_t           level [N_SRC],
    input  logic [N_SRC-1:0] xfer,
    output logic             win_valid,
    output logic [IDW-1:0]   win_id,
    output level_t           win_level,
    output logic             win_xfer
);
    localparam int LEAVES = 1 << IDW;
    localparam int NODES  = 2 * LEAVES - 1;

    typedef struct packed {
        logic           v;
        logic [IDW-1:0] id;
        level_t         lvl;
        logic           x;
    } node_t;

    node_t node [NODES];

    genvar gl, gk;
    generate
        for (gl = 0; gl < LEAVES; gl++) begin : g_leaf
            if (gl < N_SRC) begin : g_real
                // Leaf carries one source's request.
                assign node[LEAVES-1+gl] = '{v: live[gl], id: IDW'(gl), lvl: level[gl], x: xfer[gl]};
            end else begin : g_pad
                // Padding leaf never wins.
                assign node[LEAVES-1+gl] = '{v: 1'b0, id: '0, lvl: LVL_NEVER, x: 1'b0};
            end
        end
        for (gk = 0; gk < LEAVES - 1; gk++) begin : g_node
            logic take_right;
            // Right child wins only if strictly more urgent; left holds lower indices.
            assign take_right = node[2*gk+2].v &&
                                (!node[2*gk+1].v || (node[2*gk+2].lvl < node[2*gk+1].lvl));
            assign node[gk] = take_right ? node[2*gk+2] : node[2*gk+1];
        end
    endgenerate

    // Root of the tournament is the overall winner.
    assign win_valid = node[0].v;
    assign win_id    = node[0].id;
    assign win_level = node[0].lvl;
    assign win_xfer  = node[0].x;
endmodule

// File: rtl/irq_accept_ctl.sv
// Decides whether the current winner is taken at an instruction boundary,
// registers the one-cycle take pulse, and keeps the running level mask.
// Assumes the winner inputs are stable around the clock edge.
module irq_accept_ctl
    import irq_arb_pkg::*;
#(
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_valid,
    input  logic [IDW-1:0] win_id,
    input  level_t         win_level,
    input  logic           win_xfer,
    input  logic           gie,
    input  logic           boundary,
    input  logic           mask_ld,
    input  level_t         mask_ld_val,
    output logic           acc_valid,
    output logic [IDW-1:0] acc_id,
    output level_t         acc_level,
    output logic           acc_xfer,
    output level_t         mask
);
    logic take;

    // Take the winner only at a boundary, globally enabled, strictly below the mask.
    assign take = boundary && gie && win_valid && (win_level < mask);

    // Register the take pulse and capture the taken request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_id    <= '0;
            acc_level <= '0;
            acc_xfer  <= 1'b0;
        end else begin
            acc_valid <= take;
            if (take) begin
                acc_id    <= win_id;
                acc_level <= win_level;
                acc_xfer  <= win_xfer;
            end
        end
    end

    // Running mask: a normal take loads its level; otherwise a direct load applies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= MASK_RESET;
        end else if (take && !win_xfer) begin
            mask <= win_level;
        end else if (mask_ld) begin
            mask <= mask_ld_val;
        end
    end

    // R5: a pulse always follows a boundary strobe.
    a_r5_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(boundary));
    // R5: the pulse lasts a single cycle unless a new boundary take followed.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !$past(boundary, 1)) |-> 1'b0);
    // R4: a take needs global enable and a level strictly below the old mask.
    a_r4_gie_set: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(gie));
    a_r4_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_valid) |-> (acc_level < $past(mask)));
    // R7: a normal take leaves the mask equal to the taken level.
    a_r7_mask_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_xfer) |-> (mask == acc_level));
    // R10: level 7 is never taken.
    a_r10_never_top: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_level != LVL_NEVER));
endmodule

// File: rtl/irq_prio_arbiter.sv
// Top level of the priority interrupt arbiter: gates requests, runs the
// combinational priority tournament, and times the take at instruction
// boundaries against a running level mask.
// Assumes inputs change only between rising clock edges.
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 16,
    localparam int IDW = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq_flag,
    input  logic [N_SRC-1:0]       irq_en,
    input  logic [LVL_W*N_SRC-1:0] irq_level,
    input  logic [N_SRC-1:0]       irq_xfer_sel,
    input  logic                   int_enable,
    input  logic                   insn_boundary,
    input  logic                   mask_load,
    input  logic [LVL_W-1:0]       mask_load_val,
    output logic                   pend_valid,
    output logic [IDW-1:0]         pend_id,
    output logic [LVL_W-1:0]       pend_level,
    output logic                   pend_xfer,
    output logic                   take_valid,
    output logic [IDW-1:0]         take_id,
    output logic [LVL_W-1:0]       take_level,
    output logic                   take_xfer,
    output logic [LVL_W-1:0]       level_mask
);
    logic [N_SRC-1:0] live;
    level_t           lvl [N_SRC];

    irq_req_gate #(.N_SRC(N_SRC)) u_gate (
        .flag      (irq_flag),
        .en        (irq_en),
        .level_bus (irq_level),
        .live      (live),
        .level     (lvl)
    );

    irq_prio_tree #(.N_SRC(N_SRC)) u_tree (
        .live      (live),
        .level     (lvl),
        .xfer      (irq_xfer_sel),
        .win_valid (pend_valid),
        .win_id    (pend_id),
        .win_level (pend_level),
        .win_xfer  (pend_xfer)
    );

    irq_accept_ctl #(.IDW(IDW)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid   (pend_valid),
        .win_id      (pend_id),
        .win_level   (pend_level),
        .win_xfer    (pend_xfer),
        .gie         (int_enable),
        .boundary    (insn_boundary),
        .mask_ld     (mask_load),
        .mask_ld_val (mask_load_val),
        .acc_valid   (take_valid),
        .acc_id      (take_id),
        .acc_level   (take_level),
        .acc_xfer    (take_xfer),
        .mask        (level_mask)
    );

    // R1: a winner exists exactly when some source is flagged and enabled.
    a_r1_pend_iff_live: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid == (|(irq_flag & irq_en)));
    // R1: the reported winner is itself a live source.
    a_r1_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (irq_flag[pend_id] && irq_en[pend_id]));
    // R2: the reported level is the winner's own level field.
    a_r2_level_match: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_level == irq_level[LVL_W*pend_id +: LVL_W]));
    // R6: the reported route is the winner's own select bit.
    a_r6_route_match: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_xfer == irq_xfer_sel[pend_id]));
    // R5: the take carries the source that was winning at the boundary edge.
    a_r5_take_id: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(take_valid) |-> (take_id == $past(pend_id)));
endmodule

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;
    localparam int N   = 16;
    localparam int IDW = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N-1:0]     irq_flag, irq_en, irq_xfer_sel;
    logic [3*N-1:0]   irq_level;
    logic             int_enable, insn_boundary, mask_load;
    logic [2:0]       mask_load_val;
    logic             pend_valid, pend_xfer, take_valid, take_xfer;
    logic [IDW-1:0]   pend_id, take_id;
    logic [2:0]       pend_level, take_level, level_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [2:0] m_mask;
    bit         m_tv;
    int         m_tid;
    logic [2:0] m_tlvl;
    bit         m_tx;

    always #2.5 clk = ~clk;

    irq_prio_arbiter #(.N_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en),
        .irq_level(irq_level), .irq_xfer_sel(irq_xfer_sel), .int_enable(int_enable),
        .insn_boundary(insn_boundary), .mask_load(mask_load), .mask_load_val(mask_load_val),
        .pend_valid(pend_valid), .pend_id(pend_id), .pend_level(pend_level), .pend_xfer(pend_xfer),
        .take_valid(take_valid), .take_id(take_id), .take_level(take_level), .take_xfer(take_xfer),
        .level_mask(level_mask)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference winner: smallest level, ties to the smallest index.
    function automatic void ref_win(output bit v, output int id, output logic [2:0] l,
                                    output bit tie);
        v = 0; id = 0; l = 3'd7; tie = 0;
        for (int i = 0; i < N; i++) begin
            if (irq_flag[i] && irq_en[i]) begin
                logic [2:0] li;
                li = irq_level[3*i +: 3];
                if (!v || li < l) begin
                    v = 1; id = i; l = li; tie = 0;
                end else if (li == l) begin
                    tie = 1;
                end
            end
        end
    endfunction

    // One cycle: inputs already driven at a falling edge.
    task automatic run_cycle(input string ctx);
        bit v, tie, tk;
        int id;
        logic [2:0] l;
        #1;
        ref_win(v, id, l, tie);
        check(pend_valid == v, {"R1 pend_valid ", ctx}, pend_valid, v);
        if (v) begin
            check(pend_id == id, tie ? {"R3 tie winner ", ctx} : {"R2 winner ", ctx}, pend_id, id);
            check(pend_level == l, {"R2 level ", ctx}, pend_level, l);
        end
        tk = insn_boundary && int_enable && v && (l < m_mask);
        m_tv = tk;
        if (tk) begin
            m_tid = id; m_tlvl = l; m_tx = irq_xfer_sel[id];
        end
        if (tk && !irq_xfer_sel[id]) m_mask = l;
        else if (mask_load) m_mask = mask_load_val;
        @(negedge clk);
        check(take_valid == m_tv, {"R4 R5 R10 take_valid ", ctx}, take_valid, m_tv);
        if (m_tv && take_valid) begin
            check(take_id == m_tid, {"R5 take_id ", ctx}, take_id, m_tid);
            check(take_level == m_tlvl, {"R5 take_level ", ctx}, take_level, m_tlvl);
            check(take_level != 3'd7, {"R10 level seven ", ctx}, take_level, 0);
            check(take_xfer == m_tx, {"R6 take_xfer ", ctx}, take_xfer, m_tx);
        end
        check(level_mask == m_mask, {"R7 R8 level_mask ", ctx}, level_mask, m_mask);
    endtask

    task automatic clear_inputs();
        irq_flag = '0; irq_en = '0; irq_xfer_sel = '0; irq_level = '1;
        int_enable = 0; insn_boundary = 0; mask_load = 0; mask_load_val = '0;
    endtask

    task automatic set_src(input int i, input logic [2:0] l, input bit x);
        irq_flag[i] = 1; irq_en[i] = 1; irq_level[3*i +: 3] = l; irq_xfer_sel[i] = x;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        clear_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        check(take_valid == 0, "R9 take_valid after reset", take_valid, 0);
        check(level_mask == 3'd7, "R9 mask after reset", level_mask, 7);
        m_mask = 3'd7; m_tv = 0; m_tid = 0; m_tlvl = 0; m_tx = 0;

        // R1: flag without enable, enable without flag
        irq_flag[2] = 1; irq_level[6 +: 3] = 3'd1; irq_en[5] = 1;
        int_enable = 1; insn_boundary = 1;
        run_cycle("R1 gated off");

        // R3: tie between 3 and 9 at level 2, normal route
        clear_inputs(); int_enable = 1; insn_boundary = 1;
        set_src(9, 3'd2, 0); set_src(3, 3'd2, 0); set_src(12, 3'd4, 1);
        run_cycle("R3 tie take");
        // mask now 2; same request again is refused (R4 equal level)
        run_cycle("R4 equal mask refused");

        // R8: direct load of mask back to 7, then R10 level-7 only
        clear_inputs(); mask_load = 1; mask_load_val = 3'd7;
        run_cycle("R8 load");
        clear_inputs(); int_enable = 1; insn_boundary = 1; set_src(0, 3'd7, 0);
        run_cycle("R10 level seven");

        // R4: global enable off
        clear_inputs(); insn_boundary = 1; set_src(6, 3'd0, 0);
        run_cycle("R4 gie off");
        // R5: no boundary
        int_enable = 1; insn_boundary = 0;
        run_cycle("R5 no boundary");
        // R6/R7: transfer route leaves mask
        irq_xfer_sel[6] = 1; insn_boundary = 1;
        run_cycle("R6 R7 xfer take");
        // R8: load and normal take together; take wins
        irq_xfer_sel[6] = 0; mask_load = 1; mask_load_val = 3'd5;
        run_cycle("R8 precedence");
        // R1: withdrawing the flag
        irq_flag[6] = 0; mask_load = 1; mask_load_val = 3'd7;
        run_cycle("R1 withdraw");

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N; i++) begin
                irq_flag[i] = ($urandom % 4) == 0;
                irq_en[i] = ($urandom % 4) != 0;
                irq_level[3*i +: 3] = 3'($urandom);
                irq_xfer_sel[i] = ($urandom % 4) == 0;
            end
            int_enable = ($urandom % 8) != 0;
            insn_boundary = ($urandom % 2) == 0;
            mask_load = ($urandom % 5) == 0;
            mask_load_val = ($urandom % 3 == 0) ? 3'd7 : 3'($urandom);
            run_cycle("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule